// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device side of a byte-wide parallel NOR flash model. It watches bus write cycles, takes each command byte on the rising edge of the write enable, and tracks multi-cycle unlock sequences. The write enable is sampled on the clock. When a valid command completes, the block does one of three things: it returns to array reads, it enters an identifier mode, or it starts a self-timed chip erase.

A read strobe returns one of three things, chosen by the current mode:
- the stored byte;
- an identifier byte selected by the two low address bits;
- an erase status byte.

The array is a small register bank. The erase first writes zeros to every location and then waits a set number of cycles before writing the blank value. While the erase runs, the status byte reports progress, and it also reports a timeout failure.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode. A read returns the byte at index addr_i[3:0], and that byte holds (index XOR 3Ch).
- R2: An unlock prefix is AAh written to 555h followed by 55h written to 2AAh. Any write that breaks a sequence returns the block to array-read mode and leaves identifier mode.
- R3: Identifier mode is entered by the unlock prefix followed by 90h written to 555h. In this mode a read with addr_i[1:0]=00 returns C2h.
- R4: In identifier mode a read with addr_i[1:0]=01 returns B0h when TOP_BOOT=1 and 34h when TOP_BOOT=0.
- R5: In identifier mode a read with addr_i[1]=1 returns 01h when PROT_MASK has a 1 at the bit indexed by addr_i[11:10], and 00h otherwise. The default PROT_MASK is 0101b.
- R6: A write of F0h to any address, at any point outside a running erase, returns the block to array-read mode. It also discards a partial sequence and clears an erase failure.
- R7: The chip erase sequence has six cycles: the unlock prefix, 80h written to 555h, the unlock prefix again, and 10h written to 555h. The erase starts at the rising write-enable edge of the final cycle. The first read after that edge returns status with bit 7 = 0.
- R8: While the erase runs, each status read returns bit 7 = 0 and bit 5 = 0. Bit 6 reads 0 on the first status read after the start and then inverts on every later status read.
- R9: The erase writes 00h to every location and then writes FFh to every location, all without outside control. When it completes, the block is back in array-read mode. Every read then returns FFh, so bit 7 is 1 and bit 6 no longer toggles.
- R10: If force_timeout_i is high during the erase, or the elapsed count reaches LIMIT_CYCLES, the erase stops in a failure state. In that state status reads return bit 7 = 0 and bit 5 = 1, with bit 6 still toggling. Locations already programmed keep the value 00h.
- R11: While the erase runs, every write is ignored, F0h included. In the failure state, every write other than F0h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address for writes and reads |
| data_i | input | 8 | Write data / command byte |
| we_i | input | 1 | Write enable; the command is taken on its rising edge |
| rd_i | input | 1 | Read strobe; rd_data_o updates at the same clock edge |
| force_timeout_i | input | 1 | Forces an erase timeout (test input) |
| rd_data_o | output | 8 | Read data: array, identifier or status byte |

## Verification
Sequences are driven in four forms: well-formed, broken by a wrong address, broken by a wrong data byte, and cut short by F0h. These separate the sequence tracker from the mode register. Identifier reads at several sector addresses separate the manufacturer, device and protection paths. Polling during an erase shows the bit 6 toggle until the blank data appears. A write injected during the erase shows that the write gate holds. A forced timeout, followed by reads of zeroed locations after F0h, tells the failure path apart from normal completion.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_S1, SQ_S2, SQ_S3
  } seq_e;

  typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_ERASE} phase_e;

  typedef struct packed {
    logic reset;
    logic id;
    logic erase;
    logic abort;
  } cmd_ev_t;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] MFR_CODE    = 8'hC2;
  localparam logic [7:0] DEV_TOP     = 8'hB0;
  localparam logic [7:0] DEV_BOT     = 8'h34;
  localparam logic [7:0] INIT_XOR    = 8'h3C;
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              fail_i,
  output cmd_ev_t           ev_o
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] A_ALT = ADDR_W'('h2AA);

  seq_e state_q, state_d;
  logic hit_u1, hit_u2, at_cmd;

  assign hit_u1 = (addr_i == A_CMD) && (data_i == CMD_UNLOCK1);
  assign hit_u2 = (addr_i == A_ALT) && (data_i == CMD_UNLOCK2);
  assign at_cmd = (addr_i == A_CMD);

  always_comb begin
    ev_o    = '0;
    state_d = state_q;
    if (wr_i) begin
      if (data_i == CMD_RESET) begin
        ev_o.reset = 1'b1;
        state_d    = SQ_IDLE;
      end else if (!fail_i) begin
        state_d = SQ_IDLE;
        unique case (state_q)
          SQ_IDLE: if (hit_u1) state_d = SQ_U1; else ev_o.abort = 1'b1;
          SQ_U1:   if (hit_u2) state_d = SQ_U2; else ev_o.abort = 1'b1;
          SQ_U2: begin
            if (at_cmd && data_i == CMD_IDENT)      ev_o.id = 1'b1;
            else if (at_cmd && data_i == CMD_SETUP) state_d = SQ_S1;
            else                                    ev_o.abort = 1'b1;
          end
          SQ_S1:   if (hit_u1) state_d = SQ_S2; else ev_o.abort = 1'b1;
          SQ_S2:   if (hit_u2) state_d = SQ_S3; else ev_o.abort = 1'b1;
          SQ_S3: begin
            if (at_cmd && data_i == CMD_CHIP) ev_o.erase = 1'b1;
            else                              ev_o.abort = 1'b1;
          end
          default: ev_o.abort = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  // R2: a broken sequence leaves the tracker idle
  assert_abort_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.abort |=> state_q == SQ_IDLE);
  // R11: in failure only F0h moves the tracker
  assert_fail_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && fail_i && data_i != CMD_RESET) |=> $stable(state_q));
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int BUSY_CYCLES  = 20,
  parameter int LIMIT_CYCLES = 200,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BC_W  = $clog2(BUSY_CYCLES + 1),
  localparam int LC_W  = $clog2(LIMIT_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             force_timeout_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             busy_o,
  output logic             fail_o,
  output logic [7:0]       rd_byte_o
);
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [BC_W-1:0]  bcnt_q;
  logic [LC_W-1:0]  elapsed_q;
  logic             fail_q;
  logic [7:0]       mem_q [DEPTH];
  logic             timeout;

  assign busy_o    = (phase_q != PH_IDLE);
  assign fail_o    = fail_q;
  assign rd_byte_o = mem_q[rd_idx_i];
  assign timeout   = force_timeout_i || (elapsed_q == LC_W'(LIMIT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      bcnt_q    <= '0;
      elapsed_q <= '0;
      fail_q    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'(i) ^ INIT_XOR;
    end else begin
      if (clear_i) fail_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q   <= PH_PROG;
          idx_q     <= '0;
          bcnt_q    <= '0;
          elapsed_q <= '0;
        end
        default: begin
          elapsed_q <= elapsed_q + 1'b1;
          if (timeout) begin
            fail_q  <= 1'b1;
            phase_q <= PH_IDLE;
          end else if (phase_q == PH_PROG) begin
            mem_q[idx_q] <= 8'h00;  // pre-program to zero
            if (idx_q == IDX_W'(DEPTH - 1)) phase_q <= PH_ERASE;
            else                            idx_q   <= idx_q + 1'b1;
          end else begin
            if (bcnt_q == BC_W'(BUSY_CYCLES - 1)) begin
              for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
              phase_q <= PH_IDLE;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_busy_fail_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && fail_o));
  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !fail_o) |=> busy_o);
  assert_done_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !fail_o) |-> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECTORS = 4,
  parameter logic [SECTORS-1:0] PROT_MASK = 4'b0101,
  parameter bit TOP_BOOT = 1'b1,
  localparam int SEC_W = $clog2(SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              id_mode_i,
  input  logic              busy_i,
  input  logic              fail_i,
  input  logic              start_i,
  input  logic [7:0]        array_byte_i,
  output logic [7:0]        rd_data_o
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOT;

  logic             tog_q;
  logic [SEC_W-1:0] sec;
  logic [7:0]       rd_d;
  logic             status;

  assign sec    = addr_i[ADDR_W-1 -: SEC_W];
  assign status = busy_i || fail_i;

  always_comb begin
    if (status)             rd_d = {1'b0, tog_q, fail_i, 5'b0};
    else if (id_mode_i) begin
      if (addr_i[1])        rd_d = {7'b0, PROT_MASK[sec]};
      else if (addr_i[0])   rd_d = DEV_CODE;
      else                  rd_d = MFR_CODE;
    end else                rd_d = array_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (start_i)                tog_q <= 1'b0;
      else if (rd_i && status)    tog_q <= ~tog_q;
      if (rd_i) rd_data_o <= rd_d;
    end
  end

  assert_status_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_i) |=> (rd_data_o[7] == 1'b0 && rd_data_o[5] == 1'b0));
  assert_q6_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && status && !start_i) |=> rd_data_o[6] != tog_q);
  assert_fail_q5_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fail_i) |=> rd_data_o[5]);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int ARRAY_DEPTH  = 16,
  parameter int BUSY_CYCLES  = 20,
  parameter int LIMIT_CYCLES = 200,
  parameter int SECTORS      = 4,
  parameter logic [SECTORS-1:0] PROT_MASK = 4'b0101,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic              force_timeout_i,
  output logic [7:0]        rd_data_o
);
  localparam int IDX_W = $clog2(ARRAY_DEPTH);

  logic    we_q, wr_edge, busy, fail, id_mode_q;
  cmd_ev_t ev;
  logic [7:0] array_byte;

  assign wr_edge = we_i && !we_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b0;
      id_mode_q <= 1'b0;
    end else begin
      we_q <= we_i;
      if (ev.reset || ev.abort || ev.erase) id_mode_q <= 1'b0;
      else if (ev.id)                       id_mode_q <= 1'b1;
    end
  end

  flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_edge),
    .addr_i (addr_i),
    .data_i (data_i),
    .fail_i (fail),
    .ev_o   (ev)
  );

  flash_erase_engine #(
    .DEPTH       (ARRAY_DEPTH),
    .BUSY_CYCLES (BUSY_CYCLES),
    .LIMIT_CYCLES(LIMIT_CYCLES)
  ) u_eng (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (ev.erase),
    .clear_i         (ev.reset),
    .force_timeout_i (force_timeout_i),
    .rd_idx_i        (addr_i[IDX_W-1:0]),
    .busy_o          (busy),
    .fail_o          (fail),
    .rd_byte_o       (array_byte)
  );

  flash_read_path #(
    .ADDR_W   (ADDR_W),
    .SECTORS  (SECTORS),
    .PROT_MASK(PROT_MASK),
    .TOP_BOOT (TOP_BOOT)
  ) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd_i),
    .addr_i       (addr_i),
    .id_mode_i    (id_mode_q),
    .busy_i       (busy),
    .fail_i       (fail),
    .start_i      (ev.erase),
    .array_byte_i (array_byte),
    .rd_data_o    (rd_data_o)
  );

  assert_busy_not_id_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !id_mode_q);
  assert_busy_no_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we_i && !we_q) |=> !id_mode_q);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, rd = 1'b0, force_to = 1'b0;
  logic [7:0]  rdata;
  int vectors = 0, errs = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(wdata),
    .we_i(we), .rd_i(rd), .force_timeout_i(force_to), .rd_data_o(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; we = 0; rd = 0; force_to = 0;
    repeat (2) @(negedge clk); rst_ni = 1'b1; @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_b(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic start_erase();
    unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    rd_b(12'h000, d); chk("R1 idx0", d, 8'h3C);
    rd_b(12'h105, d); chk("R1 idx5", d, 8'h05 ^ 8'h3C);
    rd_b(12'h00F, d); chk("R1 idx15", d, 8'h0F ^ 8'h3C);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    do_reset();
    unlock(); wr(12'h555, 8'h90);
    rd_b(12'h000, d); chk("R3 mfr", d, 8'hC2);
    rd_b(12'h001, d); chk("R4 dev top", d, 8'hB0);
    rd_b(12'h002, d); chk("R5 sec0 prot", d, 8'h01);
    rd_b(12'h402, d); chk("R5 sec1 unprot", d, 8'h00);
    rd_b(12'h803, d); chk("R5 sec2 prot", d, 8'h01);
    rd_b(12'hC02, d); chk("R5 sec3 unprot", d, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    unlock(); wr(12'h555, 8'h90);
    wr(12'h100, 8'h12);
    rd_b(12'h000, d); chk("R2 stray write exits id", d, 8'h3C);
    wr(12'h555, 8'hAA); wr(12'h123, 8'h55); wr(12'h555, 8'h90);
    rd_b(12'h000, d); chk("R2 wrong addr no id", d, 8'h3C);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h56); wr(12'h555, 8'h90);
    rd_b(12'h001, d); chk("R2 wrong data no id", d, 8'h01 ^ 8'h3C);
    unlock(); wr(12'h555, 8'h90);
    rd_b(12'h000, d); chk("R2 clean sequence still works", d, 8'hC2);
  endtask

  task automatic t_reset_cmd();
    logic [7:0] d;
    do_reset();
    unlock(); wr(12'h555, 8'h90);
    wr(12'h007, 8'hF0);
    rd_b(12'h000, d); chk("R6 F0 exits id", d, 8'h3C);
    unlock(); wr(12'h3FF, 8'hF0); wr(12'h555, 8'h90);
    rd_b(12'h000, d); chk("R6 F0 discards partial", d, 8'h3C);
  endtask

  task automatic t_erase();
    logic [7:0] d, prev;
    int n;
    do_reset();
    start_erase();
    rd_b(12'h005, d); chk("R7 status right after start", d, 8'h00);
    rd_b(12'h005, d); chk("R8 Q6 toggles", d, 8'h40);
    wr(12'h000, 8'hF0);
    rd_b(12'h005, d); chk("R11 F0 ignored while busy", d, 8'h00);
    prev = d; n = 0;
    while (n < 200) begin
      rd_b(12'h005, d);
      n++;
      if (d == 8'hFF) break;
      chk("R8 busy status Q6 alternates", d, {1'b0, ~prev[6], 6'b0});
      prev = d;
    end
    chk("R9 erase completes blank", d, 8'hFF);
    rd_b(12'h005, d); chk("R9 Q6 stops toggling", d, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      rd_b(12'(i), d); chk("R9 all locations blank", d, 8'hFF);
    end
  endtask

  task automatic t_fail();
    logic [7:0] d, p;
    do_reset();
    start_erase();
    repeat (20) @(negedge clk);
    force_to = 1'b1; @(negedge clk); force_to = 1'b0;
    rd_b(12'h003, p); chk("R10 fail Q7/Q5", p & 8'hA0, 8'h20);
    rd_b(12'h003, d); chk("R10 fail Q6 toggles", d, p ^ 8'h40);
    wr(12'h555, 8'hAA);
    rd_b(12'h003, p); chk("R11 non-F0 ignored in fail", p & 8'hA0, 8'h20);
    wr(12'h000, 8'hF0);
    rd_b(12'h003, d); chk("R6 F0 clears fail, zeroed data", d, 8'h00);
    rd_b(12'h00F, d); chk("R10 programmed locations stay zero", d, 8'h00);
  endtask

  initial begin
    t_reset_state();
    t_ident();
    t_abort();
    t_reset_cmd();
    t_erase();
    t_fail();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    vectors++; errs++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule